// File: doc/BRIEF.md
# Fine-Resolution Double-Buffered PWM Channel

This block produces one pulse-width-modulated output from a 10-bit duty value. The upper eight duty bits are compared against the count of a period timer, and the lower two bits are compared against the oscillator-phase index within each timer tick. This gives four output steps for every timer step. Each clock of `clk` is one oscillator phase. The timers themselves live outside the block and arrive as buses. Each bus carries a count, a phase index, a period-start pulse and the period limit.

Software writes the duty value as two independent fields: a high byte and a 2-bit low field. The writes land in holding (master) registers. The active (slave) copy takes the held value only when the selected timer starts a new period, so a period never mixes old and new duty values. The read port always shows the active copy. A select input chooses which of two time bases drives the channel. A change of selection takes effect at the next period start of the newly chosen timer.

Top module: `finepwm_chan`

## Requirements
- R1: `rd_duty` is {high byte, low field}. A high-byte write supplies bits 9:2 and a low-field write supplies bits 1:0.
- R2: `pwm_out` is registered. It is high in the cycle after one in which {count, phase} is less than the active duty value.
- R3: Writes change only the holding registers. `rd_duty` and the compared duty change only on the clock edge that closes a cycle with the selected time base's period-start pulse. On that edge they take the holding value that was present before that edge.
- R4: An active duty of zero keeps `pwm_out` low for the whole period.
- R5: A nonzero duty forces `pwm_out` high at period start, which is count 0 and phase 0.
- R6: When the high duty byte equals the period limit, `pwm_out` is low for 4 minus the low field phases at the end of the period. This is 4 phases when the low field is 0 and 1 phase when it is 3.
- R7: When the high duty byte exceeds the period limit, `pwm_out` stays high for the entire period.
- R8: `tb_sel` = 0 selects time base A (`a_*` inputs), and `tb_sel` = 1 selects time base B (`b_*` inputs).
- R9: The high and low holding fields are written independently. A write to one leaves the other unchanged, and both fields transfer together.
- R10: A change of `tb_sel` takes effect on the period-start pulse of the newly selected time base. Until then the previous time base keeps driving the channel.
- R11: Synchronous reset clears the holding and active duty values, drives `pwm_out` low and selects time base A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-phase clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_hi | input | 1 | Write strobe for the high duty byte |
| wr_hi_data | input | 8 | High duty byte |
| wr_lo | input | 1 | Write strobe for the low duty field |
| wr_lo_data | input | 2 | Low duty field |
| tb_sel | input | 1 | Time-base select (0 = A, 1 = B) |
| a_count | input | 8 | Time base A count |
| a_phase | input | 2 | Time base A phase index |
| a_start | input | 1 | Time base A period-start pulse |
| a_period | input | 8 | Time base A period limit |
| b_count | input | 8 | Time base B count |
| b_phase | input | 2 | Time base B phase index |
| b_start | input | 1 | Time base B period-start pulse |
| b_period | input | 8 | Time base B period limit |
| pwm_out | output | 1 | PWM output |
| rd_duty | output | 10 | Active duty value |

## Verification
The following are checked by the assertions on every cycle:
- the reset state;
- a zero duty holding the output low;
- the high level at period start;
- the full-high level when the duty byte exceeds the period;
- the active duty holding steady between period starts and loading the holding value on a start.

Only the bench's scenarios can show the exact falling phase for each duty value, including the 1-to-4-phase low tail when the byte equals the period. The same applies to independent field writes and to the delayed hand-over after `tb_sel` changes. For these the bench compares the output of every cycle against a reference model.

// File: rtl/finepwm_pkg.sv
package finepwm_pkg;
  typedef enum logic {TB_A = 1'b0, TB_B = 1'b1} tb_sel_e;
endpackage

// File: rtl/finepwm_tbmux.sv
module finepwm_tbmux
  import finepwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_req,
  input  logic [CNT_W-1:0]  a_count,
  input  logic [FRAC_W-1:0] a_phase,
  input  logic              a_start,
  input  logic [CNT_W-1:0]  a_period,
  input  logic [CNT_W-1:0]  b_count,
  input  logic [FRAC_W-1:0] b_phase,
  input  logic              b_start,
  input  logic [CNT_W-1:0]  b_period,
  output logic [CNT_W-1:0]  eff_count,
  output logic [FRAC_W-1:0] eff_phase,
  output logic              eff_start,
  output logic [CNT_W-1:0]  eff_period
);
  tb_sel_e act_q;
  tb_sel_e eff_sel;
  logic    req_start;

  // the requested base only takes over on its own period start
  assign req_start = sel_req ? b_start : a_start;
  assign eff_sel   = req_start ? tb_sel_e'(sel_req) : act_q;

  always_ff @(posedge clk) begin
    if (rst) act_q <= TB_A;
    else     act_q <= eff_sel;
  end

  always_comb begin
    if (eff_sel == TB_B) begin
      eff_count  = b_count;
      eff_phase  = b_phase;
      eff_start  = b_start;
      eff_period = b_period;
    end else begin
      eff_count  = a_count;
      eff_phase  = a_phase;
      eff_start  = a_start;
      eff_period = a_period;
    end
  end
endmodule

// File: rtl/finepwm_duty_latch.sv
module finepwm_duty_latch #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  localparam int DUTY_W = CNT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi,
  input  logic [CNT_W-1:0]  wr_hi_data,
  input  logic              wr_lo,
  input  logic [FRAC_W-1:0] wr_lo_data,
  input  logic              xfer,
  output logic [DUTY_W-1:0] hold_duty,
  output logic [DUTY_W-1:0] act_duty
);
  logic [CNT_W-1:0]  hold_hi;
  logic [FRAC_W-1:0] hold_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_hi <= '0;
      hold_lo <= '0;
    end else begin
      if (wr_hi) hold_hi <= wr_hi_data;
      if (wr_lo) hold_lo <= wr_lo_data;
    end
  end

  assign hold_duty = {hold_hi, hold_lo};

  always_ff @(posedge clk) begin
    if (rst)       act_duty <= '0;
    else if (xfer) act_duty <= hold_duty;
  end
endmodule

// File: rtl/finepwm_cmp.sv
module finepwm_cmp #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  localparam int DUTY_W = CNT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] duty,
  input  logic [CNT_W-1:0]  count,
  input  logic [FRAC_W-1:0] phase,
  input  logic [CNT_W-1:0]  period,
  output logic              pwm
);
  logic [CNT_W-1:0] duty_hi;
  logic             full_on;
  logic             below;
  logic             level;

  assign duty_hi = duty[DUTY_W-1:FRAC_W];
  assign full_on = duty_hi > period;
  assign below   = {count, phase} < duty;
  assign level   = (duty != '0) && (full_on || below);

  always_ff @(posedge clk) begin
    if (rst) pwm <= 1'b0;
    else     pwm <= level;
  end
endmodule

// File: rtl/finepwm_chan.sv
module finepwm_chan #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  localparam int DUTY_W = CNT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi,
  input  logic [CNT_W-1:0]  wr_hi_data,
  input  logic              wr_lo,
  input  logic [FRAC_W-1:0] wr_lo_data,
  input  logic              tb_sel,
  input  logic [CNT_W-1:0]  a_count,
  input  logic [FRAC_W-1:0] a_phase,
  input  logic              a_start,
  input  logic [CNT_W-1:0]  a_period,
  input  logic [CNT_W-1:0]  b_count,
  input  logic [FRAC_W-1:0] b_phase,
  input  logic              b_start,
  input  logic [CNT_W-1:0]  b_period,
  output logic              pwm_out,
  output logic [DUTY_W-1:0] rd_duty
);
  logic [CNT_W-1:0]  eff_count;
  logic [FRAC_W-1:0] eff_phase;
  logic              eff_start;
  logic [CNT_W-1:0]  eff_period;
  logic [DUTY_W-1:0] hold_duty;
  logic [DUTY_W-1:0] act_duty;
  logic [DUTY_W-1:0] cmp_duty;

  finepwm_tbmux #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_tbmux (
    .clk(clk), .rst(rst), .sel_req(tb_sel),
    .a_count(a_count), .a_phase(a_phase), .a_start(a_start), .a_period(a_period),
    .b_count(b_count), .b_phase(b_phase), .b_start(b_start), .b_period(b_period),
    .eff_count(eff_count), .eff_phase(eff_phase), .eff_start(eff_start),
    .eff_period(eff_period)
  );

  finepwm_duty_latch #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_latch (
    .clk(clk), .rst(rst),
    .wr_hi(wr_hi), .wr_hi_data(wr_hi_data),
    .wr_lo(wr_lo), .wr_lo_data(wr_lo_data),
    .xfer(eff_start), .hold_duty(hold_duty), .act_duty(act_duty)
  );

  // on a period start the new value is already in force for the first phase
  assign cmp_duty = eff_start ? hold_duty : act_duty;

  finepwm_cmp #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_cmp (
    .clk(clk), .rst(rst), .duty(cmp_duty),
    .count(eff_count), .phase(eff_phase), .period(eff_period),
    .pwm(pwm_out)
  );

  assign rd_duty = act_duty;
endmodule

// File: rtl/finepwm_chan_chk.sv
module finepwm_chan_chk #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  localparam int DUTY_W = CNT_W + FRAC_W
) (
  input logic              clk,
  input logic              rst,
  input logic              pwm_out,
  input logic [DUTY_W-1:0] rd_duty,
  input logic              eff_start,
  input logic [CNT_W-1:0]  eff_count,
  input logic [FRAC_W-1:0] eff_phase,
  input logic [CNT_W-1:0]  eff_period,
  input logic [DUTY_W-1:0] hold_duty
);
  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (!pwm_out && rd_duty == '0));

  p_zero_low_r4: assert property (@(posedge clk) disable iff (rst)
    (!eff_start && rd_duty == '0) |=> !pwm_out);

  p_start_high_r5: assert property (@(posedge clk) disable iff (rst)
    (eff_start && eff_count == '0 && eff_phase == '0 && hold_duty != '0) |=> pwm_out);

  p_full_high_r7: assert property (@(posedge clk) disable iff (rst)
    (!eff_start && rd_duty[DUTY_W-1:FRAC_W] > eff_period) |=> pwm_out);

  p_hold_steady_r3: assert property (@(posedge clk) disable iff (rst)
    !eff_start |=> $stable(rd_duty));

  p_transfer_r9: assert property (@(posedge clk) disable iff (rst)
    eff_start |=> (rd_duty == $past(hold_duty)));
endmodule

bind finepwm_chan finepwm_chan_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .pwm_out(pwm_out), .rd_duty(rd_duty),
  .eff_start(eff_start), .eff_count(eff_count), .eff_phase(eff_phase),
  .eff_period(eff_period), .hold_duty(hold_duty)
);

// File: tb/finepwm_chan_test.sv
`timescale 1ns/1ps
module finepwm_chan_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic       wr_hi = 0, wr_lo = 0, tb_sel = 0;
  logic [7:0] wr_hi_data = 0;
  logic [1:0] wr_lo_data = 0;
  logic [7:0] pa = 8'd5, pb = 8'd9;
  logic [7:0] a_cnt, b_cnt;
  logic [1:0] a_ph, b_ph;
  logic       a_st, b_st;
  logic       pwm_out;
  logic [9:0] rd_duty;

  int checks = 0, fails = 0, cyc = 0;

  assign a_st = (a_cnt == 0) && (a_ph == 0);
  assign b_st = (b_cnt == 0) && (b_ph == 0);

  always @(posedge clk) begin
    if (rst) begin
      a_cnt <= 0; a_ph <= 0; b_cnt <= 0; b_ph <= 0;
    end else begin
      a_ph <= a_ph + 1'b1;
      b_ph <= b_ph + 1'b1;
      if (a_ph == 2'd3) a_cnt <= (a_cnt >= pa) ? 8'd0 : a_cnt + 1'b1;
      if (b_ph == 2'd3) b_cnt <= (b_cnt >= pb) ? 8'd0 : b_cnt + 1'b1;
    end
  end

  finepwm_chan uut (
    .clk(clk), .rst(rst), .wr_hi(wr_hi), .wr_hi_data(wr_hi_data),
    .wr_lo(wr_lo), .wr_lo_data(wr_lo_data), .tb_sel(tb_sel),
    .a_count(a_cnt), .a_phase(a_ph), .a_start(a_st), .a_period(pa),
    .b_count(b_cnt), .b_phase(b_ph), .b_start(b_st), .b_period(pb),
    .pwm_out(pwm_out), .rd_duty(rd_duty)
  );

  function automatic logic want_level(logic [9:0] d, logic [7:0] c, logic [1:0] p, logic [7:0] per);
    if (d == 0) return 1'b0;
    if (d[9:2] > per) return 1'b1;
    return ({c, p} < d);
  endfunction

  function automatic string level_tag(logic [9:0] d, logic [7:0] c, logic [1:0] p, logic [7:0] per);
    if (d == 0) return "R4";
    if (c == 0 && p == 0) return "R5";
    if (d[9:2] > per) return "R7";
    if (d[9:2] == per) return "R6";
    return "R2";
  endfunction

  // reference model of the channel's externally visible behaviour
  logic [7:0] m_hi;
  logic [1:0] m_lo;
  logic [9:0] m_act;
  logic       m_sel;
  logic       m_pwm;
  string      m_tag;
  always @(posedge clk) begin : mdl
    logic       s, st;
    logic [9:0] d;
    logic [7:0] c, per;
    logic [1:0] p;
    if (rst) begin
      m_hi <= 0; m_lo <= 0; m_act <= 0; m_sel <= 0; m_pwm <= 0; m_tag <= "R11";
    end else begin
      s   = (tb_sel ? b_st : a_st) ? tb_sel : m_sel;
      st  = s ? b_st : a_st;
      c   = s ? b_cnt : a_cnt;
      p   = s ? b_ph : a_ph;
      per = s ? pb : pa;
      d   = st ? {m_hi, m_lo} : m_act;
      m_pwm <= want_level(d, c, p, per);
      m_tag <= level_tag(d, c, p, per);
      if (st) m_act <= {m_hi, m_lo};
      m_sel <= s;
      if (wr_hi) m_hi <= wr_hi_data;
      if (wr_lo) m_lo <= wr_lo_data;
    end
  end

  string scen = "reset";

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (pwm_out !== m_pwm) begin
        fails++;
        $display("FAIL %s R8 R10 [%s] pwm_out=%0b expected=%0b cyc=%0d", m_tag, scen, pwm_out, m_pwm, cyc);
      end
      checks++;
      if (rd_duty !== m_act) begin
        fails++;
        $display("FAIL R3 [%s] rd_duty=%h expected=%h cyc=%0d", scen, rd_duty, m_act, cyc);
      end
    end
  end

  task automatic expect_duty(string tag, logic [9:0] exp);
    checks++;
    if (rd_duty !== exp) begin
      fails++;
      $display("FAIL %s rd_duty=%h expected=%h", tag, rd_duty, exp);
    end
  endtask

  task automatic write_hi(logic [7:0] v);
    wr_hi = 1; wr_hi_data = v;
    @(negedge clk); wr_hi = 0;
  endtask

  task automatic write_lo(logic [1:0] v);
    wr_lo = 1; wr_lo_data = v;
    @(negedge clk); wr_lo = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle(3);
    rst = 0;
    @(negedge clk);
    // R11: reset state
    checks++;
    if (pwm_out !== 1'b0) begin
      fails++; $display("FAIL R11 pwm_out=%0b expected=0", pwm_out);
    end
    expect_duty("R11", 10'h000);

    scen = "compose";
    write_hi(8'h03); write_lo(2'd2);
    expect_duty("R3 held", 10'h000);
    idle(30);
    expect_duty("R1", 10'h00E);

    scen = "lo only";
    write_lo(2'd1);
    idle(30);
    expect_duty("R9", 10'h00D);

    scen = "hi equals period";
    for (int l = 0; l < 4; l++) begin
      write_hi(pa); write_lo(2'(l));
      idle(60);
    end

    scen = "full";
    write_hi(pa + 8'd1);
    idle(40);
    scen = "zero";
    write_hi(0); write_lo(0);
    idle(40);

    scen = "switch to B";
    write_hi(8'd4); write_lo(2'd3);
    tb_sel = 1;
    idle(80);
    scen = "switch to A";
    tb_sel = 0;
    idle(80);

    scen = "random";
    for (int k = 0; k < 6000; k++) begin
      int r;
      r = int'($urandom_range(0, 999));
      if (r < 100) begin
        case ($urandom_range(0, 3))
          0: wr_hi_data = 8'($urandom_range(0, 24));
          1: wr_hi_data = tb_sel ? pb : pa;
          2: wr_hi_data = (tb_sel ? pb : pa) + 8'd1;
          default: wr_hi_data = 0;
        endcase
        wr_hi = 1;
      end else if (r < 200) begin
        wr_lo_data = 2'($urandom_range(0, 3));
        wr_lo = 1;
      end else if (r < 206) begin
        tb_sel = ~tb_sel;
      end else if (r < 209) begin
        pa = 8'($urandom_range(0, 20));
      end else if (r < 212) begin
        pb = 8'($urandom_range(0, 20));
      end
      @(negedge clk);
      wr_hi = 0; wr_lo = 0;
    end
    finish_run();
  end
endmodule